// File: doc/BRIEF.md
# Ethernet MAC Enable and Local Reset Controller

This block holds the global run control of an Ethernet MAC. A single host-visible register has two live bits: an enable bit that permits the receive and transmit paths to run, and a local reset bit that clears itself once its reset sequence has finished. While the sequence runs, the block drives a local reset output. That output aborts any receive or transmit work under way and returns the other controller registers to their reset values.

Hardware clears the enable bit in three cases: when a local reset starts, when the transmitter reports a fatal error, and when the receiver reports one. Once enable is low, receive stops in the next cycle. Transmit is wound down gently instead. The block raises a stop request to the transmitter and holds it until the transmitter acknowledges. The transmitter sends that acknowledge after it has closed the frame in flight with a deliberately corrupted CRC, or one cycle after the request if it was idle.

Top module: `mac_ctl_top`

## Requirements
- R1: After the asynchronous reset (rst_n low), rd_data reads zero, and reset_busy, rx_enable, tx_enable and tx_stop_req are all low.
- R2: rd_data bit 1 is the enable bit and bit 0 is the local reset bit. Bits REG_W-1 down to 2 always read zero.
- R3: A host write with wr_data bit 0 set, made while no sequence runs, raises reset_busy and rd_data bit 0 on the next cycle. Both stay high for exactly SEQ_LEN (default 8) cycles and then drop together.
- R4: Starting a local reset clears the enable bit and cancels any pending transmit stop request on the next cycle. Enable stays low when the sequence ends.
- R5: Host writes made while reset_busy is high have no effect on the enable bit, and they do not restart or lengthen the sequence.
- R6: A high tx_fatal or rx_fatal at a clock edge clears the enable bit. It also wins over a host write that sets enable in the same cycle.
- R7: rx_enable follows the enable bit, so receive stops in the cycle after enable is cleared.
- R8: When enable falls outside a local reset, tx_stop_req rises on the next cycle. It holds until tx_stop_done is seen high, and falls on the next cycle. tx_enable stays high while the stop request is pending.
- R9: A host write that sets enable while tx_stop_req is high is ignored.
- R10: A host write made while no sequence and no stop request are active, with wr_data bit 0 clear, loads wr_data bit 1 into the enable bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host register write strobe |
| wr_data | input | REG_W | Host write data |
| rd_data | output | REG_W | Register read value |
| tx_fatal | input | 1 | Transmit fatal-error event |
| rx_fatal | input | 1 | Receive fatal-error event |
| tx_stop_done | input | 1 | Transmitter reports that shutdown is complete |
| rx_enable | output | 1 | Receive path permitted to run |
| tx_enable | output | 1 | Transmit path permitted to run or finish |
| tx_stop_req | output | 1 | Graceful stop request to the transmitter |
| reset_busy | output | 1 | Local reset sequence active; aborts datapaths and clears other registers |

## Verification
The hardest case to reach is a local reset that arrives while a graceful transmit stop is still waiting for its acknowledge. The bench reaches it by giving its transmitter stub a long frame, so the stop request stays high for several cycles, and then writing the reset bit while that request is still up. Writes to the enable bit made during the reset sequence and during a pending stop are also driven on purpose. The reference model predicts every output on every cycle, so a wrongly accepted write shows up at rd_data at once.

// File: rtl/mac_ctl_pkg.sv
package mac_ctl_pkg;
   localparam int EN_BIT  = 1;
   localparam int RST_BIT = 0;
   localparam int LIVE_BITS = 2;

   typedef enum logic {
      TXS_RUN  = 1'b0,
      TXS_STOP = 1'b1
   } txs_t;
endpackage

// File: rtl/mac_ctl_rst_seq.sv
module mac_ctl_rst_seq #(
   parameter int SEQ_LEN = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy
);
   localparam int CW = (SEQ_LEN > 1) ? $clog2(SEQ_LEN) : 1;
   localparam logic [CW-1:0] LAST = CW'(SEQ_LEN - 1);

   generate
      if (SEQ_LEN < 1) begin : g_bad_len
         $error("mac_ctl_rst_seq: SEQ_LEN must be at least 1");
      end
      if (SEQ_LEN == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     busy <= 1'b0;
            else if (busy)  busy <= 1'b0;
            else            busy <= start;
         end
      end else begin : g_count
         logic [CW-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               busy <= 1'b0;
               cnt  <= '0;
            end else if (busy) begin
               if (cnt == LAST) begin
                  busy <= 1'b0;
                  cnt  <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end else if (start) begin
               busy <= 1'b1;
               cnt  <= '0;
            end
         end
      end
   endgenerate
endmodule

// File: rtl/mac_ctl_tx_stop.sv
module mac_ctl_tx_stop
   import mac_ctl_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic kill,
   input  logic en_q,
   input  logic en_d,
   input  logic done,
   output logic stop_req
);
   txs_t st;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= TXS_RUN;
      end else if (kill) begin
         st <= TXS_RUN;
      end else begin
         case (st)
            TXS_RUN:  if (en_q && !en_d) st <= TXS_STOP;
            TXS_STOP: if (done)          st <= TXS_RUN;
            default:                     st <= TXS_RUN;
         endcase
      end
   end

   assign stop_req = (st == TXS_STOP);
endmodule

// File: rtl/mac_ctl_top.sv
module mac_ctl_top
   import mac_ctl_pkg::*;
#(
   parameter int REG_W   = 32,
   parameter int SEQ_LEN = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [REG_W-1:0] wr_data,
   output logic [REG_W-1:0] rd_data,
   input  logic             tx_fatal,
   input  logic             rx_fatal,
   input  logic             tx_stop_done,
   output logic             rx_enable,
   output logic             tx_enable,
   output logic             tx_stop_req,
   output logic             reset_busy
);
   localparam int PAD_W = REG_W - LIVE_BITS;
   localparam int LEN_W = $clog2(SEQ_LEN + 2) + 1;

   generate
      if (REG_W <= LIVE_BITS) begin : g_bad_w
         $error("mac_ctl_top: REG_W must exceed the live bit count");
      end
   endgenerate

   logic en_q, en_d, start, kill;

   assign start = wr_en && wr_data[RST_BIT] && !reset_busy;
   assign kill  = start || reset_busy;

   always_comb begin
      en_d = en_q;
      if (kill)                          en_d = 1'b0;
      else if (tx_fatal || rx_fatal)     en_d = 1'b0;
      else if (wr_en && !tx_stop_req)    en_d = wr_data[EN_BIT];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) en_q <= 1'b0;
      else        en_q <= en_d;
   end

   mac_ctl_rst_seq #(.SEQ_LEN(SEQ_LEN)) u_seq (
      .clk   (clk),
      .rst_n (rst_n),
      .start (start),
      .busy  (reset_busy)
   );

   mac_ctl_tx_stop u_stop (
      .clk      (clk),
      .rst_n    (rst_n),
      .kill     (kill),
      .en_q     (en_q),
      .en_d     (en_d),
      .done     (tx_stop_done),
      .stop_req (tx_stop_req)
   );

   assign rd_data   = {{PAD_W{1'b0}}, en_q, reset_busy};
   assign rx_enable = en_q;
   assign tx_enable = en_q || tx_stop_req;

   // ---------------- assertions ----------------
   logic [LEN_W-1:0] busy_run;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          busy_run <= '0;
      else if (reset_busy) busy_run <= busy_run + 1'b1;
      else                 busy_run <= '0;
   end

   p_busy_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(reset_busy) |-> (busy_run == LEN_W'(SEQ_LEN)));

   p_busy_max_r3: assert property (@(posedge clk) disable iff (!rst_n)
      reset_busy |-> (busy_run < LEN_W'(SEQ_LEN)));

   p_reset_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
      reset_busy |-> (!en_q && !tx_stop_req));

   p_busy_ignores_wr_r5: assert property (@(posedge clk) disable iff (!rst_n)
      reset_busy |=> !en_q);

   p_fatal_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_fatal || rx_fatal) |=> !en_q);

   p_stop_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_stop_req && !tx_stop_done && !kill) |=> tx_stop_req);

   p_stop_blocks_en_r9: assert property (@(posedge clk) disable iff (!rst_n)
      tx_stop_req |=> !en_q);
endmodule

// File: tb/sim_mac_ctl_top.sv
`timescale 1ns/1ps
module sim_mac_ctl_top;
   localparam int REG_W = 32;
   localparam int SEQ_LEN = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_en = 1'b0;
   logic [REG_W-1:0] wr_data = '0;
   logic tx_fatal = 1'b0, rx_fatal = 1'b0, tx_stop_done = 1'b0;
   logic [REG_W-1:0] rd_data;
   logic rx_enable, tx_enable, tx_stop_req, reset_busy;

   always #2 clk = ~clk;   // 250 MHz

   mac_ctl_top #(.REG_W(REG_W), .SEQ_LEN(SEQ_LEN)) u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .rd_data(rd_data), .tx_fatal(tx_fatal), .rx_fatal(rx_fatal),
      .tx_stop_done(tx_stop_done), .rx_enable(rx_enable),
      .tx_enable(tx_enable), .tx_stop_req(tx_stop_req),
      .reset_busy(reset_busy)
   );

   int errors = 0, checks = 0, cycles = 0;
   bit compare_on = 0;

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s act=%0h exp=%0h at cycle %0d", tag, act, exp, cycles);
      end
   endtask

   // transmitter stub: acknowledges after frame_len cycles of stop request
   int frame_len = 0;
   int stop_age = 0;
   always @(negedge clk) begin
      tx_stop_done <= tx_stop_req && (stop_age >= frame_len);
      if (tx_stop_req) stop_age <= stop_age + 1;
      else             stop_age <= 0;
   end

   // behavioural reference model
   bit m_en = 0, m_stop = 0;
   int m_left = 0;
   always @(posedge clk) begin
      bit busy, st, nen, nstop;
      if (!rst_n) begin
         m_en = 0; m_stop = 0; m_left = 0;
      end else begin
         busy = (m_left > 0);
         st = !busy && wr_en && wr_data[0];
         if (busy || st)                 nen = 0;
         else if (tx_fatal || rx_fatal)  nen = 0;
         else if (wr_en && !m_stop)      nen = wr_data[1];
         else                            nen = m_en;
         if (busy || st)                 nstop = 0;
         else if (m_stop && tx_stop_done) nstop = 0;
         else if (m_en && !nen)          nstop = 1;
         else                            nstop = m_stop;
         m_left = busy ? m_left - 1 : (st ? SEQ_LEN : 0);
         m_en = nen; m_stop = nstop;
      end
   end

   always @(negedge clk) begin
      cycles++;
      if (compare_on) begin
         chk(rd_data == {30'b0, m_en, m_left > 0}, "R2 rd_data", rd_data, {30'b0, m_en, m_left > 0});
         chk(reset_busy == (m_left > 0), "R3 reset_busy", reset_busy, m_left > 0);
         chk(rx_enable == m_en, "R7 rx_enable", rx_enable, m_en);
         chk(tx_stop_req == m_stop, "R8 tx_stop_req", tx_stop_req, m_stop);
         chk(tx_enable == (m_en || m_stop), "R8 tx_enable", tx_enable, m_en || m_stop);
      end
      if (cycles > 20000) begin
         errors++; checks++;
         $display("FAIL watchdog expired act=%0d exp=<20000", cycles);
         report();
      end
   end

   task automatic report();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   task automatic tick(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic host_wr(input logic [REG_W-1:0] d);
      wr_en = 1'b1; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0; wr_data = '0;
   endtask

   initial begin
      int busy_cycles;
      tick(3);
      rst_n = 1'b1;
      @(negedge clk);
      compare_on = 1;
      // R1 reset state
      chk(rd_data == 0 && !reset_busy && !rx_enable && !tx_enable && !tx_stop_req,
          "R1 reset state", rd_data, 0);

      // R10 set enable
      host_wr(32'h2);
      chk(rd_data == 32'h2 && rx_enable, "R10 enable set", rd_data, 32'h2);
      // R2 reserved bits ignored
      host_wr(32'hFFFF_FFFE);
      chk(rd_data == 32'h2, "R2 reserved bits read zero", rd_data, 32'h2);

      // R7/R8 disable with idle transmitter
      frame_len = 0;
      host_wr(32'h0);
      chk(!rx_enable, "R7 rx stops next cycle", rx_enable, 0);
      chk(tx_stop_req && tx_enable, "R8 stop request raised", tx_stop_req, 1);
      tick(1);
      chk(!tx_stop_req && !tx_enable, "R8 idle ack ends stop", tx_stop_req, 0);

      // R9 set attempt during pending stop
      host_wr(32'h2);
      frame_len = 5;
      host_wr(32'h0);
      tick(1);
      host_wr(32'h2);
      chk(rd_data[1] == 1'b0 && tx_stop_req, "R9 enable write ignored", rd_data, 0);
      tick(8);
      chk(!tx_stop_req, "R8 stop released after ack", tx_stop_req, 0);
      chk(rd_data[1] == 1'b0, "R9 enable still clear", rd_data, 0);

      // R6 fatal errors
      frame_len = 0;
      host_wr(32'h2);
      tx_fatal = 1'b1; tick(1); tx_fatal = 1'b0;
      chk(!rx_enable, "R6 tx fatal clears enable", rx_enable, 0);
      tick(3);
      host_wr(32'h2);
      rx_fatal = 1'b1; wr_en = 1'b1; wr_data = 32'h2;
      tick(1);
      rx_fatal = 1'b0; wr_en = 1'b0; wr_data = '0;
      chk(rd_data[1] == 1'b0, "R6 rx fatal beats host set", rd_data, 0);
      tick(3);

      // R3/R4/R5 local reset
      host_wr(32'h2);
      host_wr(32'h3);
      busy_cycles = 0;
      chk(rd_data == 32'h1, "R4 reset clears enable", rd_data, 32'h1);
      host_wr(32'h2);   // R5 ignored
      busy_cycles = 1;
      chk(rd_data[1] == 1'b0, "R5 enable write ignored during reset", rd_data, 0);
      host_wr(32'h1);   // R5 no restart
      busy_cycles = 2;
      while (reset_busy && busy_cycles < 20) begin
         tick(1);
         busy_cycles++;
      end
      busy_cycles = busy_cycles - 1;
      chk(busy_cycles + 1 == SEQ_LEN, "R3 busy length", busy_cycles + 1, SEQ_LEN);
      chk(rd_data == 0, "R3 reset bit self-clears", rd_data, 0);

      // R4 reset during pending stop
      frame_len = 10;
      host_wr(32'h2);
      host_wr(32'h0);
      tick(2);
      chk(tx_stop_req, "R8 long frame stop pending", tx_stop_req, 1);
      host_wr(32'h1);
      chk(!tx_stop_req && reset_busy, "R4 reset aborts stop", tx_stop_req, 0);
      tick(SEQ_LEN + 2);
      chk(!tx_stop_req && rd_data == 0, "R4 quiet after reset", rd_data, 0);

      report();
   end
endmodule